// File: doc/BRIEF.md
# Pipelined Burst SRAM with Per-Cycle Command Decoder

This block models a pipelined synchronous burst SRAM whose read path deselects in a single cycle. The control pins are sampled on every rising clock edge. A priority decoder reduces them to one action per cycle: snooze, deselect, start a burst at the external address, step the burst to its next address, or hold the burst at its current address. The burst address walks a four-word group in linear or interleaved order. Writes are byte-lane masked, and each lane is eight data bits plus one parity bit.

Read data comes from an output pipeline register. The block has no bidirectional pin. The data bus is given as a data output plus a drive-enable output, and a low drive-enable stands for high impedance. The output enable and the snooze input act on the drive-enable without waiting for a clock edge.

Top module: `sync_burst_sram`

## Requirements
- R1: While `snooze` is high, `rdata_oe` is 0. A snooze cycle performs no access and ends any open burst, so later step or hold cycles neither read nor write until a new burst starts.
- R2: The part is selected only when `en1_n`=0, `en2`=1 and `en3_n`=0. An accepted strobe while the part is not selected (`pstb_n`=0 with `en1_n`=0, or `cstb_n`=0) is a deselect. It ends the burst, and `rdata_oe` is 0 after the second following clock edge.
- R3: `pstb_n`=0 with the part selected starts a read burst at `addr`, whatever the write inputs are. When `en1_n`=1, `pstb_n` is ignored.
- R4: `cstb_n`=0 with `pstb_n`=1 and the part selected starts a burst at `addr`. That first beat is a write when the write term is active and a read otherwise.
- R5: With both strobes inactive (or `en1_n`=1 and `cstb_n`=1) and `adv_n`=0, an open burst moves to its next address and reads there, or writes there when the write term is active.
- R6: Under the same strobe conditions with `adv_n`=1, an open burst stays at its current address, and the beat counter keeps its value.
- R7: The write term is active when `gwr_n`=0 (all lanes written), or when `bwr_n`=0 and at least one bit of `lane_wr_n` is 0 (the lanes whose bit is 0 are written). Lane i covers bits [9i+8:9i] of `wdata`, and bit 9i+8 is its parity bit.
- R8: For a read action sampled at clock edge k, the word is on `rdata` after edge k+1, with `rdata_oe`=1 for that one cycle when `oe_n`=0 and `snooze`=0.
- R9: `oe_n`=1 forces `rdata_oe` to 0 without waiting for a clock edge. The read and the burst still advance internally.
- R10: With `ilv_mode`=0 latched at burst start, the low two address bits of beat c are (base+c) mod 4, and the upper bits stay those of the base address.
- R11: With `ilv_mode`=1 latched at burst start, the low two address bits of beat c are base XOR c.
- R12: A step or hold cycle with no open burst performs no access: nothing is written and `rdata_oe` stays 0.
- R13: After reset, no burst is open, `rdata_oe` is 0 and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snooze | input | 1 | Power-down request, highest priority |
| en1_n | input | 1 | Active-low primary chip enable, which also qualifies `pstb_n` |
| en2 | input | 1 | Active-high chip enable |
| en3_n | input | 1 | Active-low chip enable |
| pstb_n | input | 1 | Processor address strobe, always a read start |
| cstb_n | input | 1 | Controller address strobe, read or write start |
| adv_n | input | 1 | Burst advance (0 = next, 1 = hold) |
| gwr_n | input | 1 | Global write, all lanes |
| bwr_n | input | 1 | Byte-write enable |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| ilv_mode | input | 1 | Burst order, latched at burst start (1 = interleaved) |
| addr | input | AW | External word address |
| wdata | input | LANES*9 | Write data, nine bits per lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*9 | Registered read data |
| rdata_oe | output | 1 | Bus drive enable, 0 = high impedance |

## Verification
On every cycle the assertions check the bus-release rules: snooze and a high output enable always float the bus, a deselect floats it from the second following edge, and a selected processor-strobe read drives it two edges later unless it is masked. They also check that a cycle with no open burst writes nothing and that every write enables at least one lane. Only the bench's scenarios can show that the data is right. That covers which address a linear or interleaved burst reaches after steps and holds, which byte lanes and parity bits a masked write changes, and that reads which were ignored, snoozed or masked leave the array and the burst position as they were.

// File: rtl/sbs_pkg.sv
// Shared types and helpers for the pipelined burst SRAM.
// Assumes bursts are four beats long and wrap on the low two address bits.
package sbs_pkg;

    // Action picked by the per-cycle decoder.
    typedef enum logic [2:0] {
        ACT_DESEL,
        ACT_START,
        ACT_NEXT,
        ACT_HOLD,
        ACT_SNOOZE
    } sbs_act_e;

    // Low address bits of beat 'c' in a burst starting at low bits 'b'.
    function automatic logic [1:0] seq_low(input logic [1:0] b,
                                           input logic [1:0] c,
                                           input logic       ilv);
        return ilv ? (b ^ c) : (b + c);
    endfunction

endpackage

// File: rtl/sbs_decode.sv
// Per-cycle command decoder: turns the sampled control pins into one action,
// a read/write flag and a byte-lane write mask.
// Assumes the inputs are stable around the rising edge. Purely combinational.
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             snooze,
    input  logic             en1_n,
    input  logic             en2,
    input  logic             en3_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output sbs_act_e         act,
    output logic             is_wr,
    output logic [LANES-1:0] lane_we
);

    logic             sel;
    logic             wterm;
    logic [LANES-1:0] mask;

    // Chip selection and the combined write term.
    always_comb begin
        sel   = !en1_n && en2 && !en3_n;
        wterm = !gwr_n || (!bwr_n && !(&lane_wr_n));
        if (!gwr_n)      mask = '1;
        else if (!bwr_n) mask = ~lane_wr_n;
        else             mask = '0;
    end

    // Priority chain: snooze, processor strobe, controller strobe, then burst control.
    always_comb begin
        act   = ACT_HOLD;
        is_wr = 1'b0;
        if (snooze) begin
            act = ACT_SNOOZE;
        end else if (!en1_n && !pstb_n) begin
            act = sel ? ACT_START : ACT_DESEL;
        end else if (!cstb_n) begin
            act   = sel ? ACT_START : ACT_DESEL;
            is_wr = sel && wterm;
        end else begin
            act   = adv_n ? ACT_HOLD : ACT_NEXT;
            is_wr = wterm;
        end
        lane_we = is_wr ? mask : '0;
    end

endmodule

// File: rtl/sbs_burst.sv
// Burst address sequencer: latches the base address and order at burst start,
// counts beats on steps, keeps the count on holds, and closes on deselect or snooze.
// Assumes AW >= 2 so that a four-beat group fits in the low address bits.
module sbs_burst
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sbs_act_e      act,
    input  logic          ilv_mode,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] op_addr,
    output logic          op_ok,
    output logic          active
);

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          ilv_q;
    logic [1:0]    cnt_use;

    // Burst state: open/closed flag, base address, beat count and order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else begin
            case (act)
                ACT_START: begin
                    active <= 1'b1;
                    base_q <= ext_addr;
                    cnt_q  <= '0;
                    ilv_q  <= ilv_mode;
                end
                ACT_NEXT:  if (active) cnt_q <= cnt_q + 2'd1;
                ACT_DESEL,
                ACT_SNOOZE: active <= 1'b0;
                default: ;
            endcase
        end
    end

    // Address of this cycle's access and whether an access happens.
    always_comb begin
        cnt_use = (act == ACT_NEXT) ? cnt_q + 2'd1 : cnt_q;
        if (act == ACT_START)
            op_addr = ext_addr;
        else
            op_addr = {base_q[AW-1:2], seq_low(base_q[1:0], cnt_use, ilv_q)};
        op_ok = (act == ACT_START) ||
                (active && (act == ACT_NEXT || act == ACT_HOLD));
    end

endmodule

// File: rtl/sbs_array.sv
// Storage array: one word bank per byte lane, nine bits wide (data plus parity).
// Writes are masked per lane. The read port is combinational and is registered by the caller.
// Assumes a synchronous clear on reset is acceptable for the small depth.
module sbs_array #(
    parameter int LANES = 4,
    parameter int AW    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     we,
    input  logic [AW-1:0]        waddr,
    input  logic [LANES*9-1:0]   wdata,
    input  logic [AW-1:0]        raddr,
    output logic [LANES*9-1:0]   rdata
);

    localparam int LW    = 9;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] bank [DEPTH];

        // Lane bank: cleared on reset, written when its lane enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (we[g]) begin
                bank[waddr] <= wdata[g*LW +: LW];
            end
        end

        assign rdata[g*LW +: LW] = bank[raddr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Top of the pipelined burst SRAM. It decodes the command, sequences the burst
// address, writes the lanes at once, and returns read data through
// an address register and an output register (data visible one clock after the address).
// Assumes the external bus is resolved outside the block from rdata and rdata_oe.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snooze,
    input  logic               en1_n,
    input  logic               en2,
    input  logic               en3_n,
    input  logic               pstb_n,
    input  logic               cstb_n,
    input  logic               adv_n,
    input  logic               gwr_n,
    input  logic               bwr_n,
    input  logic [LANES-1:0]   lane_wr_n,
    input  logic               ilv_mode,
    input  logic [AW-1:0]      addr,
    input  logic [LANES*9-1:0] wdata,
    input  logic               oe_n,
    output logic [LANES*9-1:0] rdata,
    output logic               rdata_oe
);

    localparam int DW = LANES * 9;

    sbs_act_e          act;
    logic              is_wr;
    logic [LANES-1:0]  lane_we;
    logic [AW-1:0]     op_addr;
    logic              op_ok;
    logic              burst_active;
    logic              wr_go;
    logic [LANES-1:0]  lane_go;
    logic              rd_go;
    logic              rd_pend;
    logic [AW-1:0]     rd_addr;
    logic [DW-1:0]     arr_q;
    logic              dq_valid;
    logic [DW-1:0]     dq_q;

    sbs_decode #(.LANES(LANES)) u_dec (
        .snooze    (snooze),
        .en1_n     (en1_n),
        .en2       (en2),
        .en3_n     (en3_n),
        .pstb_n    (pstb_n),
        .cstb_n    (cstb_n),
        .adv_n     (adv_n),
        .gwr_n     (gwr_n),
        .bwr_n     (bwr_n),
        .lane_wr_n (lane_wr_n),
        .act       (act),
        .is_wr     (is_wr),
        .lane_we   (lane_we)
    );

    sbs_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .ilv_mode (ilv_mode),
        .ext_addr (addr),
        .op_addr  (op_addr),
        .op_ok    (op_ok),
        .active   (burst_active)
    );

    // Gate the decoded access with the burst-valid flag.
    always_comb begin
        wr_go   = op_ok && is_wr;
        lane_go = wr_go ? lane_we : '0;
        rd_go   = op_ok && !is_wr;
    end

    sbs_array #(.LANES(LANES), .AW(AW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lane_go),
        .waddr (op_addr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (arr_q)
    );

    // Read stage one: register the read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_pend <= rd_go;
            rd_addr <= op_addr;
        end
    end

    // Read stage two: pipeline output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_valid <= 1'b0;
            dq_q     <= '0;
        end else begin
            dq_valid <= rd_pend;
            if (rd_pend) dq_q <= arr_q;
        end
    end

    // Bus drive: asynchronous output enable and snooze override.
    always_comb begin
        rdata    = dq_q;
        rdata_oe = dq_valid && !oe_n && !snooze;
    end

endmodule

// File: rtl/sbs_checker.sv
// Property checker for sync_burst_sram, attached by bind.
// Observes the control pins, the bus enable and the burst and write gating.
module sbs_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snooze,
    input logic             en1_n,
    input logic             en2,
    input logic             en3_n,
    input logic             pstb_n,
    input logic             cstb_n,
    input logic             oe_n,
    input logic             rdata_oe,
    input logic             burst_active,
    input logic             wr_go,
    input logic [LANES-1:0] lane_go
);

    logic selected;
    assign selected = !en1_n && en2 && !en3_n;

    assert_snooze_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> !rdata_oe);

    assert_oe_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe);

    assert_desel_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && ((!en1_n && !pstb_n) || !cstb_n) && !selected) |-> ##2 !rdata_oe);

    assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && selected && !pstb_n) |-> ##2 (rdata_oe || oe_n || snooze));

    assert_idle_noaccess_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze && !burst_active && cstb_n && (en1_n || pstb_n))
            |-> !wr_go ##2 !rdata_oe);

    assert_lane_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (lane_go != '0));

endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .snooze       (snooze),
    .en1_n        (en1_n),
    .en2          (en2),
    .en3_n        (en3_n),
    .pstb_n       (pstb_n),
    .cstb_n       (cstb_n),
    .oe_n         (oe_n),
    .rdata_oe     (rdata_oe),
    .burst_active (burst_active),
    .wr_go        (wr_go),
    .lane_go      (lane_go)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random traffic,
// with every bus cycle compared against a reference model built from the requirements.
module tb_sync_burst_sram;

    localparam int LANES = 4;
    localparam int AW    = 6;
    localparam int DW    = LANES * 9;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             snooze, en1_n, en2, en3_n, pstb_n, cstb_n, adv_n;
    logic             gwr_n, bwr_n, ilv_mode, oe_n;
    logic [LANES-1:0] lane_wr_n;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    rdata;
    logic             rdata_oe;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    bit            m_act, m_ilv, e_pend;
    int            m_base, m_cnt;
    logic [DW-1:0] e_data;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.LANES(LANES), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .snooze(snooze), .en1_n(en1_n), .en2(en2),
        .en3_n(en3_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n), .ilv_mode(ilv_mode),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    // Address of the current burst beat (R10 linear, R11 interleaved).
    function automatic int beat_addr();
        int lo;
        lo = m_ilv ? ((m_base % 4) ^ m_cnt) : ((m_base + m_cnt) % 4);
        return (m_base & ~3) | lo;
    endfunction

    // Reference model of the command sampled at the edge just passed.
    task automatic model_cmd();
        bit sel, wt, isw, ok;
        int act, a;
        logic [LANES-1:0] m;
        sel = !en1_n && en2 && !en3_n;
        wt  = !gwr_n || (!bwr_n && (lane_wr_n != '1));
        m   = !gwr_n ? '1 : (!bwr_n ? ~lane_wr_n : '0);
        isw = 1'b0;
        ok  = 1'b0;
        a   = 0;
        if (snooze) act = 4;
        else if (!en1_n && !pstb_n) act = sel ? 1 : 0;
        else if (!cstb_n) begin act = sel ? 1 : 0; isw = sel && wt; end
        else begin act = adv_n ? 3 : 2; isw = wt; end
        case (act)
            1: begin m_act = 1; m_base = int'(addr); m_cnt = 0; m_ilv = ilv_mode; a = int'(addr); ok = 1; end
            2: if (m_act) begin m_cnt = (m_cnt + 1) % 4; a = beat_addr(); ok = 1; end
            3: if (m_act) begin a = beat_addr(); ok = 1; end
            default: m_act = 0;
        endcase
        e_pend = ok && !isw;
        if (e_pend) e_data = ref_mem[a];
        if (ok && isw)
            for (int l = 0; l < LANES; l++)
                if (m[l]) ref_mem[a][l*9 +: 9] = wdata[l*9 +: 9];
    endtask

    // One clock: check the bus after the edge, then update the model.
    task automatic step(input string tag);
        bit exp_oe;
        @(posedge clk);
        #1;
        exp_oe = e_pend && !oe_n && !snooze;
        chk(rdata_oe === exp_oe, tag, DW'(rdata_oe), DW'(exp_oe));
        if (exp_oe) chk(rdata === e_data, tag, rdata, e_data);
        model_cmd();
        @(negedge clk);
    endtask

    task automatic idle();
        snooze = 0; en1_n = 0; en2 = 1; en3_n = 0; pstb_n = 1; cstb_n = 1;
        adv_n = 1; gwr_n = 1; bwr_n = 1; lane_wr_n = '1; oe_n = 0;
    endtask

    task automatic cwrite(input int a, input logic [DW-1:0] d, input bit ilv, input string tag);
        idle(); cstb_n = 0; addr = AW'(a); gwr_n = 0; wdata = d; ilv_mode = ilv;
        step(tag);
    endtask

    task automatic pread(input int a, input bit ilv, input string tag);
        idle(); pstb_n = 0; addr = AW'(a); gwr_n = 0; ilv_mode = ilv;  // R3 write pins ignored
        step(tag);
    endtask

    task automatic nxt(input bit wr, input logic [DW-1:0] d, input string tag);
        idle(); adv_n = 0; gwr_n = !wr; wdata = d;
        step(tag);
    endtask

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom, $urandom};
        return t[DW-1:0];
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        m_act = 0; m_ilv = 0; e_pend = 0; m_base = 0; m_cnt = 0; e_data = '0;
        idle(); ilv_mode = 0; addr = '0; wdata = '0; rst_n = 0;
        repeat (3) @(negedge clk);
        chk(rdata_oe === 1'b0, "R13", DW'(rdata_oe), '0);  // R13 bus off in reset
        rst_n = 1;
        step("R13");
        pread(5, 0, "R13"); step("R13");                   // R13 array reads zero

        // R4 write start, R3 read start regardless of write pins
        cwrite(8, 36'h123456789, 0, "R4");
        pread(8, 0, "R3");
        step("R3");
        // R7 byte-lane write with lanes 1 and 3 only
        idle(); cstb_n = 0; addr = 9; bwr_n = 0; lane_wr_n = 4'b0101; wdata = 36'hFEDCBA987;
        step("R7");
        pread(9, 0, "R7"); step("R7");
        // R4/R7 byte-write enable with no lane -> read start
        idle(); cstb_n = 0; addr = 8; bwr_n = 0; lane_wr_n = '1; wdata = 36'h0;
        step("R4"); step("R4");

        // R10/R5 linear burst from low bits 2
        cwrite(6, 36'h111111111, 0, "R10");
        nxt(1, 36'h222222222, "R5"); nxt(1, 36'h333333333, "R5"); nxt(1, 36'h444444444, "R5");
        pread(6, 0, "R10");
        nxt(0, '0, "R10"); nxt(0, '0, "R10"); nxt(0, '0, "R10"); step("R10");
        pread(4, 0, "R10"); step("R10");
        // R11 interleaved burst from low bits 1
        cwrite(13, 36'hAAAA0000A, 1, "R11");
        nxt(1, 36'hBBBB0000B, "R11"); nxt(1, 36'hCCCC0000C, "R11"); nxt(1, 36'hDDDD0000D, "R11");
        pread(13, 1, "R11");
        nxt(0, '0, "R11"); nxt(0, '0, "R11"); nxt(0, '0, "R11"); step("R11");
        pread(12, 0, "R11"); step("R11");

        // R6 hold keeps the beat, then step
        pread(6, 0, "R6"); nxt(0, '0, "R6"); step("R6"); step("R6"); nxt(0, '0, "R6"); step("R6");
        // R3 processor strobe ignored when en1_n is high -> step
        pread(12, 1, "R3"); idle(); en1_n = 1; pstb_n = 0; addr = 40; adv_n = 0; step("R3"); step("R3");
        // R2 deselect with en2 low, then R12 idle step with write term
        idle(); en2 = 0; cstb_n = 0; step("R2"); step("R2");
        idle(); adv_n = 0; gwr_n = 0; wdata = 36'hFFFFFFFFF; step("R12"); step("R12");
        pread(12, 1, "R12"); step("R12"); pread(13, 1, "R12"); step("R12");
        // R1 snooze during a burst, then R1 no access afterwards
        pread(8, 0, "R1"); idle(); snooze = 1; step("R1");
        nxt(1, 36'h0F0F0F0F0, "R1"); step("R1");
        pread(9, 0, "R1"); step("R1");
        // R9 output enable high masks the bus, burst still advances
        pread(6, 0, "R9"); idle(); oe_n = 1; adv_n = 0; step("R9");
        nxt(0, '0, "R9"); step("R9");

        // Seeded random traffic, every read compared with the model (R8)
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            idle();
            gwr_n = ($urandom % 4) != 0;
            bwr_n = $urandom % 2;
            lane_wr_n = LANES'($urandom);
            wdata = rnd_word();
            oe_n = ($urandom % 8) == 0;
            addr = AW'($urandom % 16);
            if (r < 4) snooze = 1;
            else if (r < 10) begin
                cstb_n = 0; pstb_n = $urandom % 2;
                case ($urandom % 3)
                    0: en1_n = 1;
                    1: en2 = 0;
                    default: en3_n = 1;
                endcase
            end
            else if (r < 22) begin pstb_n = 0; ilv_mode = $urandom % 2; end
            else if (r < 36) begin cstb_n = 0; ilv_mode = $urandom % 2; end
            else if (r < 70) begin adv_n = 0; en1_n = ($urandom % 5) == 0; end
            else en1_n = ($urandom % 5) == 0;
            step("R8");
        end
        idle(); step("R8"); step("R8");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule